// File: doc/BRIEF.md
# Prefix Swap and Storage-Key Reference/Change Recorder

This block sits after address translation. Each cycle it may receive one real address together with the access's read and write permissions. It turns that address into an absolute address by exchanging two 8 KB areas. The first is the area at address zero. The second is an 8 KB area that starts at the CPU's prefix. Addresses outside both areas pass through unchanged.

In the same clock edge that registers the absolute address, the block updates a small on-chip array of storage keys. There is one key per 4 KB page. A read permission sets the key's reference bit and a write permission sets its change bit. These updates happen only when the absolute address falls within the configured memory size and inside the pages the array covers.

The resulting write is also presented on the outputs, so that a neighbouring key memory can mirror it. A combinational readback port exposes any key.

Top module: `pfx_key_unit`

## Requirements
- R1: During and after a synchronous reset, `abs_valid` and `upd_en` are low and every key reads back as zero.
- R2: A real address below 0x2000 maps to the real address plus the aligned prefix.
- R3: A real address at or above the aligned prefix and below the aligned prefix plus 0x2000 maps to the real address minus the aligned prefix. This rule applies only if R2 does not.
- R4: Every other real address maps to itself.
- R5: Bits 12..0 of `prefix` have no effect on the mapping.
- R6: `abs_addr` and `abs_valid` appear in the cycle after the edge at which `acc_valid` was sampled high. `abs_valid` is low after a cycle with `acc_valid` low.
- R7: An accepted access with `perm_rd` high sets the reference bit (bit 1) of key entry `abs_addr >> 12`.
- R8: An accepted access with `perm_wr` high sets the change bit (bit 0) of the same entry. Bits that are already set stay set.
- R9: An access is accepted for key update only if `abs_addr <= mem_size`. An address equal to `mem_size` is updated and one byte above it is not.
- R10: Keys are never altered in these cases: when `acc_valid` is low, when the page index is at or beyond the entry count (64), or when neither permission is given. Key bits 6..2 (access key and fetch-protect) are never changed by an access.
- R11: `upd_en`, `upd_idx` and `upd_key` show the key write made at the same edge, with `upd_key` equal to the key value after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access strobe |
| real_addr | input | 32 | Real address of the access |
| prefix | input | 32 | Prefix register; low 13 bits ignored |
| perm_rd | input | 1 | Access carries read permission |
| perm_wr | input | 1 | Access carries write permission |
| mem_size | input | 32 | Highest absolute address eligible for key update |
| rb_idx | input | 6 | Key readback index |
| abs_addr | output | 32 | Registered absolute address |
| abs_valid | output | 1 | `abs_addr` is valid this cycle |
| upd_en | output | 1 | A key write took place at the last edge |
| upd_idx | output | 6 | Entry written |
| upd_key | output | 7 | New key value written |
| rb_key | output | 7 | Key at `rb_idx` |

## Verification
The bench probes the window edges: 0x1FFF versus 0x2000, aligned prefix plus 0x1FFF versus plus 0x2000, and a zero prefix. A design with a wrong comparison bound would mis-map exactly one of these addresses. It also drives a prefix with its low bits set, which would shift the mapping in a design that used those bits. It places an absolute address exactly at `mem_size` and one byte above it, which catches a strict-versus-inclusive comparison error. It also sends accesses whose page index lies beyond the array, which a design that wrapped the index would wrongly write into a low entry. Finally, it repeats accesses to the same entry to show that reference and change bits are sticky and that the access-key bits never move.

// File: rtl/pfx_key_pkg.sv
package pfx_key_pkg;
  typedef struct packed {
    logic [3:0] acc_key;
    logic       fetch_prot;
    logic       ref_b;
    logic       chg_b;
  } skey_t;

  localparam int KEY_W = $bits(skey_t);
endpackage

// File: rtl/pfx_mapper.sv
module pfx_mapper #(
  parameter int AW       = 32,
  parameter int WIN_BITS = 13
) (
  input  logic [AW-1:0] real_addr,
  input  logic [AW-1:0] prefix,
  output logic [AW-1:0] abs_addr,
  output logic          hit_low,
  output logic          hit_pfx
);
  localparam logic [AW:0] WIN_SIZE = (AW+1)'(1) << WIN_BITS;

  function automatic logic [AW-1:0] align_pfx(input logic [AW-1:0] p);
    return {p[AW-1:WIN_BITS], {WIN_BITS{1'b0}}};
  endfunction

  function automatic logic in_low_win(input logic [AW-1:0] a);
    return ({1'b0, a} < WIN_SIZE);
  endfunction

  function automatic logic in_pfx_win(input logic [AW-1:0] a, input logic [AW-1:0] pb);
    return ({1'b0, a} >= {1'b0, pb}) && ({1'b0, a} < ({1'b0, pb} + WIN_SIZE));
  endfunction

  logic [AW-1:0] pbase;

  always_comb begin
    pbase   = align_pfx(prefix);
    hit_low = in_low_win(real_addr);
    hit_pfx = !hit_low && in_pfx_win(real_addr, pbase);
    if (hit_low)      abs_addr = real_addr + pbase;
    else if (hit_pfx) abs_addr = real_addr - pbase;
    else              abs_addr = real_addr;
  end

  always_comb begin
    AST_OFFSET_KEPT: assert (abs_addr[WIN_BITS-1:0] == real_addr[WIN_BITS-1:0]); // R5
  end
endmodule

// File: rtl/key_store.sv
module key_store
  import pfx_key_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic             set_ref,
  input  logic             set_chg,
  input  logic [IDX_W-1:0] rb_idx,
  output skey_t            new_key,
  output skey_t            rb_key
);
  skey_t keys [ENTRIES];

  always_comb begin
    new_key       = keys[idx];
    new_key.ref_b = keys[idx].ref_b | set_ref;
    new_key.chg_b = keys[idx].chg_b | set_chg;
    rb_key        = keys[rb_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) keys[i] <= '0;
    end else if (we) begin
      keys[idx] <= new_key;
    end
  end

  AST_REF_SET: assert property (@(posedge clk) disable iff (rst)
    (we && set_ref) |=> keys[$past(idx)].ref_b); // R7
  AST_CHG_SET: assert property (@(posedge clk) disable iff (rst)
    (we && set_chg) |=> keys[$past(idx)].chg_b); // R8
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    we |=> (keys[$past(idx)][KEY_W-1:2] == $past(keys[idx][KEY_W-1:2]))); // R10
endmodule

// File: rtl/pfx_key_unit.sv
module pfx_key_unit
  import pfx_key_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 13,
  parameter int ENTRIES   = 64,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [AW-1:0]    real_addr,
  input  logic [AW-1:0]    prefix,
  input  logic             perm_rd,
  input  logic             perm_wr,
  input  logic [AW-1:0]    mem_size,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [AW-1:0]    abs_addr,
  output logic             abs_valid,
  output logic             upd_en,
  output logic [IDX_W-1:0] upd_idx,
  output logic [KEY_W-1:0] upd_key,
  output logic [KEY_W-1:0] rb_key
);
  localparam int SPAN_BITS = PAGE_BITS + IDX_W;

  logic [AW-1:0]    abs_c;
  logic             hit_low, hit_pfx;
  logic             in_mem, in_array, do_upd;
  logic [IDX_W-1:0] page_idx;
  skey_t            new_key, rb_s;

  pfx_mapper #(.AW(AW), .WIN_BITS(WIN_BITS)) u_map (
    .real_addr(real_addr), .prefix(prefix), .abs_addr(abs_c),
    .hit_low(hit_low), .hit_pfx(hit_pfx)
  );

  always_comb begin
    in_mem   = (abs_c <= mem_size);
    in_array = ((abs_c >> SPAN_BITS) == '0);
    page_idx = abs_c[PAGE_BITS +: IDX_W];
    do_upd   = acc_valid && in_mem && in_array && (perm_rd || perm_wr);
  end

  key_store #(.ENTRIES(ENTRIES)) u_keys (
    .clk(clk), .rst(rst), .we(do_upd), .idx(page_idx),
    .set_ref(perm_rd), .set_chg(perm_wr),
    .rb_idx(rb_idx), .new_key(new_key), .rb_key(rb_s)
  );

  assign rb_key = rb_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      abs_addr  <= '0;
      abs_valid <= 1'b0;
      upd_en    <= 1'b0;
      upd_idx   <= '0;
      upd_key   <= '0;
    end else begin
      abs_valid <= acc_valid;
      upd_en    <= do_upd;
      if (acc_valid) abs_addr <= abs_c;
      if (do_upd) begin
        upd_idx <= page_idx;
        upd_key <= new_key;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> abs_valid); // R6
  AST_NO_IDLE_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !upd_en); // R10
  AST_UPD_WITHIN_SIZE: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (abs_addr <= $past(mem_size))); // R9
  AST_UPD_IDX_OF_ABS: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (upd_idx == abs_addr[PAGE_BITS +: IDX_W])); // R11
endmodule

// File: tb/tb_pfx_key_unit.sv
module tb_pfx_key_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_KEYS     = 64;

  logic        clk = 0;
  logic        rst = 1;
  logic        acc_valid = 0;
  logic [31:0] real_addr = 0, prefix = 0, mem_size = 0;
  logic        perm_rd = 0, perm_wr = 0;
  logic [5:0]  rb_idx = 0;
  logic [31:0] abs_addr;
  logic        abs_valid, upd_en;
  logic [5:0]  upd_idx;
  logic [6:0]  upd_key, rb_key;

  int n_chk = 0, n_bad = 0;
  int model_keys [N_KEYS];

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_key_unit dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .real_addr(real_addr),
    .prefix(prefix), .perm_rd(perm_rd), .perm_wr(perm_wr), .mem_size(mem_size),
    .rb_idx(rb_idx), .abs_addr(abs_addr), .abs_valid(abs_valid),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_key(upd_key), .rb_key(rb_key)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic longint ref_map(input longint ra, input longint pf);
    longint base = (pf / 8192) * 8192;
    if (ra < 8192) return (ra + base) % 64'h1_0000_0000;
    if (ra >= base && ra - base < 8192) return ra - base;
    return ra;
  endfunction

  task automatic step(input bit v, input longint ra, input longint pf,
                      input bit rd, input bit wr, input longint ms, input string req);
    longint ea;
    bit     eu;
    int     ei;
    @(negedge clk);
    acc_valid = v; real_addr = ra[31:0]; prefix = pf[31:0];
    perm_rd = rd; perm_wr = wr; mem_size = ms[31:0];
    ea = ref_map(ra, pf);
    ei = int'(ea / 4096);
    eu = v && (rd || wr) && ea <= ms && ei < N_KEYS;
    if (eu) model_keys[ei] = model_keys[ei] | (rd ? 2 : 0) | (wr ? 1 : 0);
    @(posedge clk); #1;
    check({req, " R6 valid"}, abs_valid, v);
    if (v) check({req, " abs"}, abs_addr, ea);
    check({req, " R9/R10 upd_en"}, upd_en, eu);
    if (eu) begin
      check({req, " R11 idx"}, upd_idx, ei);
      check({req, " R11 key"}, upd_key, model_keys[ei]);
    end
  endtask

  task automatic scan(input string req);
    @(negedge clk);
    acc_valid = 0;
    for (int i = 0; i < N_KEYS; i++) begin
      rb_idx = 6'(i);
      #1;
      check({req, " key readback"}, rb_key, model_keys[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N_KEYS; i++) model_keys[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 abs_valid in reset", abs_valid, 0);
    check("R1 upd_en in reset", upd_en, 0);
    @(negedge clk); rst = 0;
    scan("R1");

    step(1, 32'h1abc, 32'h8000, 1, 0, 32'hffff, "R2 low window read");
    step(1, 32'h1fff, 32'h8000, 0, 1, 32'hffff, "R2 low window top");
    step(1, 32'h8010, 32'h8000, 0, 1, 32'hffff, "R3 prefix window write");
    step(1, 32'h9fff, 32'h8000, 1, 0, 32'hffff, "R3 prefix window top");
    step(1, 32'ha000, 32'h8000, 1, 0, 32'hffff, "R4 above prefix window");
    step(1, 32'h2000, 32'h8000, 1, 1, 32'hffff, "R4 above low window");
    step(1, 32'h5123, 32'h8000, 1, 1, 32'hffff, "R4 pass through");
    step(1, 32'h0100, 32'h0000, 1, 0, 32'hffff, "R4 zero prefix");
    step(1, 32'h0100, 32'h9fff, 1, 0, 32'hffff, "R5 low bits of prefix");
    step(1, 32'h8100, 32'h9abc, 0, 1, 32'hffff, "R5 prefix window unaligned");
    step(1, 32'h3000, 32'h8000, 1, 0, 32'h3000, "R9 equal to size");
    step(1, 32'h4000, 32'h8000, 1, 0, 32'h3fff, "R9 one above size");
    step(0, 32'h6000, 32'h8000, 1, 1, 32'hffff, "R10 idle strobe");
    step(1, 32'h7000, 32'h8000, 0, 0, 32'hffff, "R10 no permission");
    step(1, 32'h40000, 32'h8000, 1, 1, 32'hffffffff, "R10 beyond array");
    step(1, 32'h1000, 32'hfffff000, 1, 1, 32'hffffffff, "R2 top prefix");
    step(1, 32'h1abc, 32'h8000, 0, 1, 32'hffff, "R8 sticky add change");
    step(1, 32'h1abc, 32'h8000, 1, 0, 32'hffff, "R7 sticky repeat");
    scan("R7 R8 R10");

    for (int n = 0; n < 400; n++) begin
      longint pf, ra, ms;
      int sel;
      pf  = longint'($urandom_range(0, 32'h3ffff));
      sel = $urandom_range(0, 2);
      if (sel == 0) ra = longint'($urandom_range(0, 32'h1fff));
      else if (sel == 1) ra = (pf / 8192) * 8192 + longint'($urandom_range(0, 32'h1fff));
      else ra = longint'($urandom_range(0, 32'h4ffff));
      ms = longint'($urandom_range(0, 32'h4ffff));
      step($urandom_range(0, 3) != 0, ra, pf, 1'($urandom), 1'($urandom), ms, "R2 R3 R4 random");
    end
    scan("R7 R8 random");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule